// File: doc/BRIEF.md
# Serial EEPROM Slave with Pause and Write Lock

This block models a small byte-wide non-volatile store that sits on a mode-0 SPI bus as a slave. It samples the bus pins (active-low select, serial clock, serial data in, active-low write lock and active-low pause) with its own system clock. It decodes an instruction byte, an address byte and a data byte from the serial stream. It answers reads on a serial output paired with an output-enable, so the output can be tri-stated at the pad.

The store holds `WORDS` bytes (128, 256 or 512) and starts at all zeros. A write first needs a set write-enable latch. It is committed when select rises, and it then occupies a modelled write cycle of `WCYC` system clocks. During that cycle the block ignores all selection. The pause input freezes a transfer in place. The write-lock input cancels a write that has not yet begun its internal cycle.

Top module: `eep_spi_slave`

## Requirements
- R1: While `cs_n` is high the block is idle: `miso_oe` is 0 one clock later, and `mosi`/`sck` activity has no effect on the store or the latch.
- R2: A transfer begins only on a high-to-low change of `cs_n` seen after reset; if `cs_n` is already low when reset ends, nothing is decoded and `miso_oe` stays 0 until `cs_n` has gone high and low again.
- R3: The first eight bits captured on rising `sck` edges form the instruction, MSB first. 0x06 sets the write-enable latch and 0x04 clears it. 0x03 is read and 0x02 is write, each with bit 3 carrying address bit 8. Any other value makes the rest of the transfer ignored.
- R4: After a read instruction, the next eight bits are address bits 7..0. Starting with the falling `sck` edge that follows the last address bit, each falling edge places the next stored bit (MSB first) on `miso` with `miso_oe` high. The address is `{instruction bit 3, address byte}` truncated to log2(`WORDS`) bits.
- R5: A read goes on to the following byte after every eight data bits, and wraps from address `WORDS`-1 to 0.
- R6: `hold_n` falling while `sck` is low pauses the transfer, and `hold_n` rising while `sck` is low resumes it. While paused, `miso_oe` is 0 and `sck`/`mosi` are ignored. After resuming, the transfer continues at the same bit position.
- R7: A write is committed on the rise of `cs_n` only if the latch is set, a whole data byte followed the address, and `wp_n` stayed high for the entire selection; otherwise the store is unchanged.
- R8: A committed write changes the store exactly `WCYC` clocks after commit and clears the latch at that point. `wp_n` changes during the cycle do not affect it.
- R9: While the write cycle runs, a new selection is ignored for its whole duration, including latch instructions and reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low slave select |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the slave |
| wp_n | input | 1 | Active-low write lock |
| hold_n | input | 1 | Active-low transfer pause |
| miso | output | 1 | Serial data out of the slave (0 when not enabled) |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
Every pin change is registered at the next system clock edge. A falling `sck` therefore shows on `miso` one clock later, and `miso_oe` follows `cs_n`, the pause state and the phase one clock after the change that caused it. The store changes `WCYC` clocks after the `cs_n` rise that committed the write. The bench holds each `sck` level for four clocks and reads `miso` just before it raises `sck`, well after the output is due. After every write it waits `WCYC`+10 clocks before reading back. The busy-window tests start their next selection within a few clocks of the commit, so they land inside the write cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } eep_phase_t;

  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_READ      = 8'h03;
  localparam logic [7:0] OP_WRITE     = 8'h02;
  localparam logic [7:0] OP_HIBIT     = 8'h08;

  // instruction match with the high address bit masked out
  function automatic logic op_match(input logic [7:0] op, input logic [7:0] base);
    return (op & ~OP_HIBIT) == base;
  endfunction

  // nine-bit address from instruction bit and address byte
  function automatic logic [8:0] join_addr(input logic hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/eep_pin_sampler.sv
module eep_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic hold_fall,
  output logic hold_rise
);
  logic cs_q, sck_q, hold_q;

  // cs_q resets low so a select held low through reset never forms a fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      sck_q  <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      sck_q  <= sck;
      hold_q <= hold_n;
    end
  end

  assign cs_fall   = !cs_n && cs_q;
  assign cs_rise   = cs_n && !cs_q;
  assign sck_rise  = sck && !sck_q;
  assign sck_fall  = !sck && sck_q;
  assign hold_fall = !hold_n && hold_q;
  assign hold_rise = hold_n && !hold_q;
endmodule

// File: rtl/eep_hold_ctl.sv
module eep_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_active,
  input  logic sck,
  input  logic hold_fall,
  input  logic hold_rise,
  output logic paused
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused <= 1'b0;
    end else if (!seq_active) begin
      paused <= 1'b0;
    end else if (!paused && hold_fall && !sck) begin
      paused <= 1'b1;
    end else if (paused && hold_rise && !sck) begin
      paused <= 1'b0;
    end
  end
endmodule

// File: rtl/eep_wcycle.sv
module eep_wcycle #(
  parameter int AW   = 9,
  parameter int WCYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_start,
  input  logic [AW-1:0] c_addr,
  input  logic [7:0]    c_data,
  output logic          busy,
  output logic          write_done,
  output logic [AW-1:0] w_addr,
  output logic [7:0]    w_data
);
  localparam int CW = $clog2(WCYC + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      w_addr <= '0;
      w_data <= '0;
    end else if (commit_start && !busy) begin
      remain <= CW'(WCYC);
      w_addr <= c_addr;
      w_data <= c_data;
    end else if (busy) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy       = remain != '0;
  assign write_done = remain == CW'(1);
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int WORDS = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave #(
  parameter int WORDS = 512,
  parameter int WCYC  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  input  logic hold_n,
  output logic miso,
  output logic miso_oe
);
  import eep_pkg::*;

  localparam int AW = $clog2(WORDS);

  logic cs_fall, cs_rise, sck_rise, sck_fall, hold_fall, hold_rise;
  logic paused, busy, write_done, commit_start;
  logic seq_active, wel, wp_bad, is_write, wfull, a8, miso_q;
  eep_phase_t phase;
  logic [2:0] bit_cnt, obit;
  logic [6:0] sr;
  logic [7:0] rx_byte, wdata, rd_byte;
  logic [AW-1:0] addr, w_addr, addr_in;
  logic [7:0] w_data;
  logic [8:0] full9;
  logic step, shift_edge, byte_done;

  eep_pin_sampler u_pins (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .hold_fall(hold_fall), .hold_rise(hold_rise)
  );

  eep_hold_ctl u_hold (
    .clk(clk), .rst_n(rst_n), .seq_active(seq_active), .sck(sck),
    .hold_fall(hold_fall), .hold_rise(hold_rise), .paused(paused)
  );

  eep_wcycle #(.AW(AW), .WCYC(WCYC)) u_wcyc (
    .clk(clk), .rst_n(rst_n), .commit_start(commit_start),
    .c_addr(addr), .c_data(wdata), .busy(busy), .write_done(write_done),
    .w_addr(w_addr), .w_data(w_data)
  );

  eep_mem #(.WORDS(WORDS), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(write_done), .waddr(w_addr),
    .wdata(w_data), .raddr(addr), .rdata(rd_byte)
  );

  assign rx_byte    = {sr, mosi};
  assign byte_done  = bit_cnt == 3'd7;
  assign step       = sck_rise && seq_active && !paused && !cs_n;
  assign shift_edge = sck_fall && seq_active && !paused && !cs_n;
  assign full9      = join_addr(a8, rx_byte);
  assign addr_in    = full9[AW-1:0];

  assign commit_start = cs_rise && seq_active && is_write && wfull &&
                        wel && !wp_bad && wp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_active <= 1'b0;
      phase      <= PH_OPC;
      bit_cnt    <= '0;
      obit       <= '0;
      sr         <= '0;
      a8         <= 1'b0;
      addr       <= '0;
      is_write   <= 1'b0;
      wfull      <= 1'b0;
      wdata      <= '0;
      wp_bad     <= 1'b0;
      miso_q     <= 1'b0;
    end else if (cs_n) begin
      seq_active <= 1'b0;
      phase      <= PH_OPC;
      bit_cnt    <= '0;
      obit       <= '0;
      is_write   <= 1'b0;
      wfull      <= 1'b0;
    end else if (cs_fall && !busy) begin
      seq_active <= 1'b1;
      phase      <= PH_OPC;
      bit_cnt    <= '0;
      obit       <= '0;
      wp_bad     <= !wp_n;
    end else if (seq_active) begin
      if (!wp_n) wp_bad <= 1'b1;
      if (step) begin
        sr      <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (byte_done) begin
          case (phase)
            PH_OPC: begin
              a8 <= rx_byte[3];
              if (op_match(rx_byte, OP_READ)) begin
                is_write <= 1'b0;
                phase    <= PH_ADDR;
              end else if (op_match(rx_byte, OP_WRITE)) begin
                is_write <= 1'b1;
                phase    <= PH_ADDR;
              end else begin
                phase    <= PH_SKIP;
              end
            end
            PH_ADDR: begin
              addr  <= addr_in;
              phase <= is_write ? PH_WDATA : PH_RDATA;
            end
            PH_WDATA: begin
              wdata <= rx_byte;
              wfull <= 1'b1;
              phase <= PH_SKIP;
            end
            default: phase <= phase;
          endcase
        end
      end
      if (shift_edge && phase == PH_RDATA) begin
        miso_q <= rd_byte[3'd7 - obit];
        obit   <= obit + 1'b1;
        if (obit == 3'd7) addr <= addr + 1'b1;
      end
    end
  end

  // write-enable latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (write_done) begin
      wel <= 1'b0;
    end else if (step && phase == PH_OPC && byte_done) begin
      if (rx_byte == OP_LATCH_SET)      wel <= 1'b1;
      else if (rx_byte == OP_LATCH_CLR) wel <= 1'b0;
    end
  end

  assign miso_oe = seq_active && !paused && phase == PH_RDATA;
  assign miso    = miso_q && miso_oe;
endmodule

// File: rtl/eep_spi_chk.sv
module eep_spi_chk #(
  parameter int WCYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic wp_n,
  input logic miso_oe,
  input logic seq_active,
  input logic paused,
  input logic busy,
  input logic wel,
  input logic commit_start,
  input logic write_done
);
  int bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else bcnt <= 0;
  end

  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !miso_oe);

  p_start_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_active) |-> $past(!cs_n));

  p_pause_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(!sck));

  p_resume_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(paused) && seq_active) |-> $past(!sck));

  p_commit_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |-> (wp_n && wel));

  p_latch_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    write_done |=> !wel);

  p_cycle_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    write_done |-> (bcnt == WCYC - 1));

  p_busy_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_active) |-> $past(!busy));
endmodule

bind eep_spi_slave eep_spi_chk #(.WCYC(WCYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .wp_n(wp_n),
  .miso_oe(miso_oe), .seq_active(seq_active), .paused(paused),
  .busy(busy), .wel(wel), .commit_start(commit_start),
  .write_done(write_done)
);

// File: tb/tb_eep_spi_slave.sv
module tb_eep_spi_slave;
  localparam int WORDS = 512;
  localparam int WCYC  = 20;
  localparam int NV    = 6;
  // {address[8:0], data[7:0]}
  localparam logic [16:0] VEC [NV] = '{
    {9'h000, 8'h5A}, {9'h1FF, 8'hA5}, {9'h0FF, 8'h3C},
    {9'h100, 8'hC3}, {9'h07F, 8'h81}, {9'h155, 8'h96}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
  logic miso, miso_oe;
  logic oe_any;
  logic done = 1'b0;
  int total = 0, bad = 0;

  eep_spi_slave #(.WORDS(WORDS), .WCYC(WCYC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .hold_n(hold_n), .miso(miso), .miso_oe(miso_oe)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    mosi = b;
    repeat (4) @(negedge clk);
    r = miso;
    oe_any = oe_any | miso_oe;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] o, output logic [7:0] i);
    logic bb;
    for (int k = 7; k >= 0; k--) begin
      sbit(o[k], bb);
      i[k] = bb;
    end
  endtask

  task automatic sel();
    @(negedge clk);
    cs_n = 1'b0;
    oe_any = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic op_only(input logic [7:0] op);
    logic [7:0] d;
    sel();
    xbyte(op, d);
    desel();
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] v);
    logic [7:0] d;
    sel();
    xbyte(8'h02 | {4'h0, a[8], 3'b000}, d);
    xbyte(a[7:0], d);
    xbyte(v, d);
    desel();
  endtask

  task automatic rd2(input logic [8:0] a, output logic [7:0] b0, output logic [7:0] b1);
    logic [7:0] d;
    sel();
    xbyte(8'h03 | {4'h0, a[8], 3'b000}, d);
    xbyte(a[7:0], d);
    xbyte(8'h00, b0);
    xbyte(8'h00, b1);
    desel();
  endtask

  task automatic settle();
    repeat (WCYC + 10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0, b1, d;
    logic bb;
    oe_any = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset oe", miso_oe, 1'b0);

    // R2: select held low since reset is not a start
    oe_any = 1'b0;
    xbyte(8'h03, d);
    xbyte(8'h00, d);
    xbyte(8'h00, d);
    chk("R2 no start without fall", oe_any, 1'b0);
    desel();
    chk("R1 oe after deselect", miso_oe, 1'b0);

    // R4: reset contents read as zero, output enabled
    rd2(9'h010, b0, b1);
    chk("R4 reset contents", b0, 8'h00);
    chk("R4 oe in read data", oe_any, 1'b1);

    // table walk: R7/R8 commit then R4 readback
    for (int v = 0; v < NV; v++) begin
      op_only(8'h06);
      wr(VEC[v][16:8], VEC[v][7:0]);
      settle();
    end
    for (int v = 0; v < NV; v++) begin
      rd2(VEC[v][16:8], b0, b1);
      chk($sformatf("R4 readback vec%0d", v), b0, VEC[v][7:0]);
    end

    // R5: wrap from top to 0
    rd2(9'h1FF, b0, b1);
    chk("R5 wrap first", b0, 8'hA5);
    chk("R5 wrap second", b1, 8'h5A);

    // R3: unknown instruction ignored
    sel();
    xbyte(8'hFF, d);
    xbyte(8'h00, d);
    xbyte(8'h00, d);
    desel();
    chk("R3 unknown op no output", oe_any, 1'b0);

    // R3: latch clear instruction blocks write
    op_only(8'h06);
    op_only(8'h04);
    wr(9'h020, 8'h77);
    settle();
    rd2(9'h020, b0, b1);
    chk("R3 latch cleared blocks write", b0, 8'h00);

    // R7: write without latch
    wr(9'h021, 8'h11);
    settle();
    rd2(9'h021, b0, b1);
    chk("R7 no latch no write", b0, 8'h00);

    // R7: partial data byte
    op_only(8'h06);
    sel();
    xbyte(8'h02, d);
    xbyte(8'h22, d);
    for (int k = 0; k < 5; k++) sbit(1'b1, bb);
    desel();
    settle();
    rd2(9'h022, b0, b1);
    chk("R7 partial byte dropped", b0, 8'h00);

    // R7: write lock pulse during selection cancels
    sel();
    xbyte(8'h02, d);
    xbyte(8'h23, d);
    for (int k = 0; k < 4; k++) sbit(1'b1, bb);
    wp_n = 1'b0;
    repeat (4) @(negedge clk);
    wp_n = 1'b1;
    for (int k = 0; k < 4; k++) sbit(1'b1, bb);
    desel();
    settle();
    rd2(9'h023, b0, b1);
    chk("R7 write lock cancels", b0, 8'h00);
    op_only(8'h04);

    // R8: write lock during the cycle has no effect
    op_only(8'h06);
    wr(9'h024, 8'h99);
    wp_n = 1'b0;
    settle();
    wp_n = 1'b1;
    rd2(9'h024, b0, b1);
    chk("R8 lock during cycle ignored", b0, 8'h99);

    // R9: read attempt during the cycle is ignored
    op_only(8'h06);
    wr(9'h025, 8'h42);
    rd2(9'h025, b0, b1);
    chk("R9 read during cycle ignored", oe_any, 1'b0);
    settle();
    rd2(9'h025, b0, b1);
    chk("R9 write landed", b0, 8'h42);

    // R9/R8: latch set during cycle ignored, latch cleared at end
    op_only(8'h06);
    wr(9'h026, 8'h11);
    op_only(8'h06);
    settle();
    wr(9'h027, 8'h22);
    settle();
    rd2(9'h027, b0, b1);
    chk("R8 R9 latch gone after cycle", b0, 8'h00);
    rd2(9'h026, b0, b1);
    chk("R8 first write landed", b0, 8'h11);

    // R6: pause mid-byte, clock ignored, resume at same bit
    sel();
    xbyte(8'h03, d);
    xbyte(8'h00, d);
    b0 = 8'h00;
    for (int k = 7; k >= 5; k--) begin
      sbit(1'b0, bb);
      b0[k] = bb;
    end
    hold_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 paused oe low", miso_oe, 1'b0);
    for (int k = 0; k < 2; k++) begin
      mosi = 1'b1;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      chk("R6 oe low while clocked", miso_oe, 1'b0);
      sck = 1'b0;
      repeat (4) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 4; k >= 0; k--) begin
      sbit(1'b0, bb);
      b0[k] = bb;
    end
    xbyte(8'h00, b1);
    desel();
    chk("R6 byte intact across pause", b0, 8'h5A);
    chk("R6 next byte in order", b1, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule